// File: doc/BRIEF.md
# Edge-Started Byte Memory with Precharge

This block models a byte-wide nonvolatile store behind an asynchronous-style parallel bus. The bus has three active-low controls (chip enable, output enable, write enable), an address and a byte-wide data path. The data path is split into an input byte, an output byte and an output-drive enable, so that a pad ring or a testbench can rebuild the tri-state bus. The block samples every control pin on a fast system clock through a two-stage synchronizer. It starts a memory cycle only when it sees chip enable fall, and it then runs a fixed access phase and a fixed precharge phase, each counted in clock cycles.

A cycle captures the address at the chip-enable falling edge and ignores the address pins after that. Whether the cycle is a read or a write depends on write enable. If write enable is already low at the falling edge, the cycle is a write and the block never drives the bus. If write enable falls later, the cycle starts as a read and becomes a write from that point. A write commits the input byte at the first rising edge of either write enable or chip enable. After chip enable returns high, a precharge must finish before a new cycle can begin. A chip-enable fall that arrives during precharge is dropped and raises a sticky error flag.

The bus is asynchronous in nature, so none of its pins use a valid/ready handshake. The controls are plain levels and the block applies no back-pressure. The address bus is 15 bits wide. The storage depth is a separate parameter, and address bits above it alias. With a storage width of 15 the array covers the full 32K bytes.

Top module: `ce_latched_mem`

## Requirements
- R1: While reset is held and directly after it, `dq_oe` is 0 and `proto_err` is 0.
- R2: A read cycle presents on `dq_out` the byte last written to the same storage location, and `dq_out` is valid whenever `dq_oe` is 1.
- R3: `dq_oe` stays 0 until T_ACC cycles after the detected chip-enable fall. After that, `dq_oe` is 1 only while `oe_n` and `ce_n` are both low. When `oe_n` is low early, driving waits for the access to end. When `oe_n` goes low late, driving starts within three clock cycles.
- R4: The address is captured in the cycle in which the chip-enable fall is detected. Changes on `addr` after that do not alter which location is read or written.
- R5: If `we_n` is low when chip enable falls, `dq_oe` stays 0 for the whole cycle, even with `oe_n` low. The write commits when chip enable rises.
- R6: If `we_n` falls after chip enable, `dq_oe` follows `oe_n` until `we_n` falls and stays 0 after that. The byte on `dq_in` commits when `we_n` rises.
- R7: Once a cycle starts it completes, even when chip enable rises before the access time ends. A write whose chip enable is high again after two cycles is still stored.
- R8: After chip enable rises, a precharge of T_PRE cycles follows. A chip-enable fall detected during precharge starts no cycle, so no drive appears while `ce_n` stays low. It also sets `proto_err`, which stays 1 until reset.
- R9: Storage spans 2^STORE_AW bytes (default STORE_AW = 12), and address bits at or above bit STORE_AW are ignored. For example, 0x1005 aliases 0x0005. Bytes in different blocks of the address space are independent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low; its falling edge starts a cycle |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W (15) | Byte address, captured at the chip-enable fall |
| dq_in | input | 8 | Byte taken from the bus on a write commit |
| dq_out | output | 8 | Byte presented for reads |
| dq_oe | output | 1 | High while the block drives the data bus |
| proto_err | output | 1 | Sticky flag for a chip-enable fall during precharge |

## Verification
Most faults in the phase sequencer show up on `dq_oe` within a few clock cycles of the control edge that exposes them. A cycle that never left access would never drive. A write flag that was not set would drive during a write cycle. A precharge that was skipped would let a dropped cycle drive the bus ten cycles later. A wrong captured address, or a write commit that was lost, shows only when the location is read back in a later cycle, so every write in the bench is followed by a read of the same and of aliased addresses. A faulty error latch shows on `proto_err` within five cycles of the early fall and again after the next reset.

// File: rtl/clm_pkg.sv
package clm_pkg;

  // Phases of one memory cycle.
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_ACCESS = 2'd1,
    PH_HOLD   = 2'd2,
    PH_PRECH  = 2'd3
  } phase_t;

  // Positions of the control pins inside the synchronized vector.
  localparam int NCTL   = 3;
  localparam int IDX_CE = 0;
  localparam int IDX_OE = 1;
  localparam int IDX_WE = 2;

endpackage

// File: rtl/clm_sync.sv
module clm_sync #(
  parameter int NBITS  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] pin_n,
  output logic [NBITS-1:0] lvl,
  output logic [NBITS-1:0] fall,
  output logic [NBITS-1:0] rise
);

  // One synchronizer chain and one edge detector per control pin.
  // Every flop resets to the inactive (high) level, so no edge is seen at startup.
  for (genvar g = 0; g < NBITS; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain <= '1;
        prev  <= 1'b1;
      end else begin
        chain <= {chain[STAGES-2:0], pin_n[g]};
        prev  <= chain[STAGES-1];
      end
    end

    assign lvl[g]  = chain[STAGES-1];
    assign fall[g] = prev & ~chain[STAGES-1];
    assign rise[g] = ~prev & chain[STAGES-1];
  end

endmodule

// File: rtl/clm_array.sv
module clm_array #(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  // Write port.
  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
  end

  // Registered read port; the output holds between reads.
  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= store[rd_addr];
  end

endmodule

// File: rtl/clm_seq.sv
module clm_seq
  import clm_pkg::*;
#(
  parameter int AW    = 12,
  parameter int T_ACC = 4,
  parameter int T_PRE = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_lvl,
  input  logic          ce_fall,
  input  logic          ce_rise,
  input  logic          oe_lvl,
  input  logic          we_lvl,
  input  logic          we_fall,
  input  logic          we_rise,
  input  logic [AW-1:0] addr_pin,
  output phase_t        phase,
  output logic [AW-1:0] lat_addr,
  output logic          mem_we,
  output logic          mem_re,
  output logic          dq_oe,
  output logic          proto_err
);

  localparam int CMAX = (T_ACC > T_PRE) ? T_ACC : T_PRE;
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] ACC_LAST = CW'(T_ACC - 1);
  localparam logic [CW-1:0] PRE_LAST = CW'(T_PRE - 1);

  logic [CW-1:0] cnt;
  logic          is_wr;
  logic          armed;
  logic          in_cycle;

  assign in_cycle = (phase == PH_ACCESS) || (phase == PH_HOLD);

  // Commit on the first rising edge of write enable or chip enable.
  assign mem_we = in_cycle && armed && (we_rise || ce_rise);
  // Array read is issued in the first access cycle; its result is ready next cycle.
  assign mem_re = (phase == PH_ACCESS) && (cnt == '0);
  // Drive only after the access, in a read, with both enables low.
  assign dq_oe  = (phase == PH_HOLD) && !is_wr && !oe_lvl && !ce_lvl && we_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      lat_addr  <= '0;
      is_wr     <= 1'b0;
      armed     <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      if (ce_fall && phase != PH_IDLE) proto_err <= 1'b1;

      if (in_cycle) begin
        if (mem_we)  armed <= 1'b0;
        if (we_fall) begin
          is_wr <= 1'b1;
          armed <= 1'b1;
        end
      end

      unique case (phase)
        PH_IDLE: begin
          if (ce_fall) begin
            lat_addr <= addr_pin;
            is_wr    <= ~we_lvl;
            armed    <= ~we_lvl;
            cnt      <= '0;
            phase    <= PH_ACCESS;
          end
        end
        PH_ACCESS: begin
          if (cnt == ACC_LAST) begin
            cnt   <= '0;
            phase <= ce_lvl ? PH_PRECH : PH_HOLD;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        PH_HOLD: begin
          if (ce_lvl) begin
            cnt   <= '0;
            phase <= PH_PRECH;
          end
        end
        PH_PRECH: begin
          if (cnt == PRE_LAST) begin
            cnt   <= '0;
            phase <= PH_IDLE;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ce_latched_mem.sv
module ce_latched_mem
  import clm_pkg::*;
#(
  parameter int ADDR_W   = 15,
  parameter int STORE_AW = 12,
  parameter int DATA_W   = 8,
  parameter int T_ACC    = 4,
  parameter int T_PRE    = 2,
  parameter int SYNC_N   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              proto_err
);

  logic [NCTL-1:0] pins_n, lvl, fall, rise;
  logic            ce_lvl, oe_lvl, we_lvl, ce_fall;
  phase_t          phase;
  logic [STORE_AW-1:0] lat_addr;
  logic            mem_we, mem_re;
  logic            ctl_unused;

  assign pins_n[IDX_CE] = ce_n;
  assign pins_n[IDX_OE] = oe_n;
  assign pins_n[IDX_WE] = we_n;

  clm_sync #(.NBITS(NCTL), .STAGES(SYNC_N)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_n (pins_n),
    .lvl   (lvl),
    .fall  (fall),
    .rise  (rise)
  );

  assign ce_lvl     = lvl[IDX_CE];
  assign oe_lvl     = lvl[IDX_OE];
  assign we_lvl     = lvl[IDX_WE];
  assign ce_fall    = fall[IDX_CE];
  assign ctl_unused = ^{fall[IDX_OE], rise[IDX_OE]};

  // Address bits above the storage depth alias.
  if (STORE_AW < ADDR_W) begin : g_alias
    logic addr_hi_unused;
    assign addr_hi_unused = ^addr[ADDR_W-1:STORE_AW];
  end

  clm_seq #(.AW(STORE_AW), .T_ACC(T_ACC), .T_PRE(T_PRE)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_lvl    (ce_lvl),
    .ce_fall   (ce_fall),
    .ce_rise   (rise[IDX_CE]),
    .oe_lvl    (oe_lvl),
    .we_lvl    (we_lvl),
    .we_fall   (fall[IDX_WE]),
    .we_rise   (rise[IDX_WE]),
    .addr_pin  (addr[STORE_AW-1:0]),
    .phase     (phase),
    .lat_addr  (lat_addr),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .dq_oe     (dq_oe),
    .proto_err (proto_err)
  );

  clm_array #(.AW(STORE_AW), .DW(DATA_W)) u_array (
    .clk     (clk),
    .wr_en   (mem_we),
    .wr_addr (lat_addr),
    .wr_data (dq_in),
    .rd_en   (mem_re),
    .rd_addr (lat_addr),
    .rd_data (dq_out)
  );

endmodule

// File: rtl/clm_checker.sv
module clm_checker
  import clm_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input phase_t phase,
  input logic   ce_lvl,
  input logic   oe_lvl,
  input logic   we_lvl,
  input logic   ce_fall,
  input logic   dq_oe,
  input logic   proto_err
);

  assert_no_drive_in_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ACCESS) |-> !dq_oe);

  assert_drive_needs_enables_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (!oe_lvl && !ce_lvl));

  assert_ce_write_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && ce_fall && !we_lvl) |=> !dq_oe);

  assert_we_low_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !we_lvl |-> !dq_oe);

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

  assert_prech_fall_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_PRECH && ce_fall) |=> (proto_err && phase != PH_ACCESS));

  assert_prech_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_PRECH) |=> (phase == PH_PRECH || phase == PH_IDLE));

endmodule

bind ce_latched_mem clm_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .phase     (phase),
  .ce_lvl    (ce_lvl),
  .oe_lvl    (oe_lvl),
  .we_lvl    (we_lvl),
  .ce_fall   (ce_fall),
  .dq_oe     (dq_oe),
  .proto_err (proto_err)
);

// File: tb/ce_latched_mem_test.sv
module ce_latched_mem_test;

  localparam int AW  = 15;
  localparam int SAW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0]    dq_in = '0;
  logic [7:0]    dq_out;
  logic          dq_oe, proto_err;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [int];
  logic [7:0] exp_q [$];
  logic       oe_prev = 1'b0;

  always #2 clk = ~clk;

  ce_latched_mem uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .proto_err(proto_err)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int slot(input logic [AW-1:0] a);
    return int'(a[SAW-1:0]);
  endfunction

  // Monitor: every new bus drive pops one expected byte (R2).
  always @(negedge clk) begin
    if (dq_oe && !oe_prev) begin
      if (exp_q.size() == 0) begin
        chk("R2 unexpected drive", 16'(dq_oe), 16'd0);
      end else begin
        chk("R2 read data", 16'(dq_out), 16'(exp_q.pop_front()));
      end
    end
    oe_prev = dq_oe;
  end

  // Write with write enable low before chip enable falls (R5).
  task automatic write_ce(input logic [AW-1:0] a, input logic [7:0] d, input int hold);
    int drove = 0;
    addr = a; dq_in = d; we_n = 1'b0; oe_n = 1'b0;
    idle(1);
    ce_n = 1'b0;
    for (int i = 0; i < hold; i++) begin
      idle(1);
      if (dq_oe) drove++;
    end
    ce_n = 1'b1;
    idle(1);
    we_n = 1'b1; oe_n = 1'b1;
    for (int i = 0; i < 10; i++) begin
      idle(1);
      if (dq_oe) drove++;
    end
    chk("R5 no drive in write", 16'(drove), 16'd0);
    model[slot(a)] = d;
  endtask

  task automatic read_cycle(input logic [AW-1:0] a);
    addr = a; oe_n = 1'b0;
    exp_q.push_back(model[slot(a)]);
    idle(1);
    ce_n = 1'b0;
    idle(12);
    ce_n = 1'b1; oe_n = 1'b1;
    idle(8);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    chk("R1 dq_oe in reset", 16'(dq_oe), 16'd0);
    chk("R1 err in reset", 16'(proto_err), 16'd0);
    rst_n = 1'b1;
    idle(3);
    chk("R1 dq_oe after reset", 16'(dq_oe), 16'd0);

    // R9: bytes in different blocks are independent
    write_ce(15'h0010, 8'hA5, 10);
    write_ce(15'h0410, 8'h3C, 10);
    write_ce(15'h0810, 8'h96, 10);
    write_ce(15'h0FF0, 8'h5A, 10);
    read_cycle(15'h0010);
    read_cycle(15'h0410);
    read_cycle(15'h0810);
    read_cycle(15'h0FF0);

    // R3: early output enable is held off until access ends
    addr = 15'h0410; oe_n = 1'b0;
    exp_q.push_back(model[slot(15'h0410)]);
    idle(1);
    ce_n = 1'b0;
    idle(4);
    chk("R3 no drive during access", 16'(dq_oe), 16'd0);
    idle(4);
    chk("R3 drive after access", 16'(dq_oe), 16'd1);
    oe_n = 1'b1;
    idle(3);
    chk("R3 oe high releases bus", 16'(dq_oe), 16'd0);
    exp_q.push_back(model[slot(15'h0410)]);
    oe_n = 1'b0;
    idle(3);
    chk("R3 late oe drives", 16'(dq_oe), 16'd1);
    ce_n = 1'b1; oe_n = 1'b1;
    idle(8);

    // R4: address changed after capture is ignored
    addr = 15'h0810; oe_n = 1'b0;
    exp_q.push_back(model[slot(15'h0810)]);
    idle(1);
    ce_n = 1'b0;
    idle(4);
    addr = 15'h0010;
    idle(8);
    ce_n = 1'b1; oe_n = 1'b1;
    idle(8);
    // R4: write with address moved mid-cycle lands at captured address
    addr = 15'h0123; dq_in = 8'h77; we_n = 1'b0;
    idle(1);
    ce_n = 1'b0;
    idle(4);
    addr = 15'h0321;
    idle(6);
    ce_n = 1'b1;
    idle(1);
    we_n = 1'b1;
    idle(8);
    model[slot(15'h0123)] = 8'h77;
    read_cycle(15'h0123);

    // R6: write-enable-controlled write after a read start
    addr = 15'h0FF0; oe_n = 1'b0; dq_in = 8'hC3;
    exp_q.push_back(model[slot(15'h0FF0)]);
    idle(1);
    ce_n = 1'b0;
    idle(10);
    chk("R6 read phase drives", 16'(dq_oe), 16'd1);
    we_n = 1'b0;
    idle(3);
    chk("R6 we low stops drive", 16'(dq_oe), 16'd0);
    idle(3);
    we_n = 1'b1;
    idle(4);
    chk("R6 no drive after write", 16'(dq_oe), 16'd0);
    ce_n = 1'b1; oe_n = 1'b1;
    idle(8);
    model[slot(15'h0FF0)] = 8'hC3;
    read_cycle(15'h0FF0);

    // R7: chip enable released early, cycle still completes
    write_ce(15'h0200, 8'h1E, 2);
    read_cycle(15'h0200);

    // R9: upper address bits alias
    write_ce(15'h1005, 8'hE1, 10);
    read_cycle(15'h0005);
    write_ce(15'h7FF0, 8'h42, 10);
    read_cycle(15'h0FF0);

    // R8: fall during precharge is dropped and flagged
    addr = 15'h0010; oe_n = 1'b0;
    exp_q.push_back(model[slot(15'h0010)]);
    idle(1);
    ce_n = 1'b0;
    idle(10);
    ce_n = 1'b1;
    idle(2);
    ce_n = 1'b0;
    idle(5);
    chk("R8 err set", 16'(proto_err), 16'd1);
    idle(12);
    chk("R8 dropped cycle no drive", 16'(dq_oe), 16'd0);
    ce_n = 1'b1; oe_n = 1'b1;
    idle(8);
    chk("R8 err sticky", 16'(proto_err), 16'd1);
    chk("R2 all reads seen", 16'(exp_q.size()), 16'd0);

    rst_n = 1'b0;
    idle(2);
    chk("R1 err cleared by reset", 16'(proto_err), 16'd0);
    rst_n = 1'b1;
    idle(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule